// File: doc/BRIEF.md
# Warp Memory Access Coalescer

This block takes one load request from a 32-lane warp. Each lane brings its own byte address and an enable bit. The block works out which 128-byte cache lines the enabled lanes touch. It then issues one memory transaction per distinct line, one per cycle, over a valid/ready handshake. Each transaction carries the line-aligned address and a bit mask of the lanes that the line serves. Element size (1, 2 or 4 bytes) reaches the block only through the lane addresses. Elements that cross a line boundary are not handled.

A request is accepted only when the previous one has fully drained. When the last transaction of a request is taken, the block raises a one-cycle completion pulse. The pulse carries the number of transactions issued, which serves as a coalescing-efficiency figure: 1 is ideal and 32 is the worst case.

Top module: `warp_coalescer`

## Requirements
- R1: Each transaction address equals the address of the lanes it serves with the low 7 bits cleared, so every transaction targets one 128-byte line.
- R2: A request whose enabled lanes touch N distinct lines produces exactly N transactions. Enabled lanes that all fall in one line produce a single transaction. For a lane stride of up to 128 bytes, N equals the number of lines from the lowest to the highest enabled address.
- R3: Transactions are issued in order of the lowest-numbered lane still pending. Bit i of `txnMask` stands for lane i. Each mask holds every pending lane whose line matches, and no lane is served twice within a request.
- R4: Lanes whose `reqMask` bit is 0 never appear in any `txnMask`, and their addresses do not affect the transactions.
- R5: A request with `reqMask` all zero issues no transaction. It raises `doneValid` with `doneCount` 0 on the cycle after acceptance.
- R6: `reqReady` is 1 only when no request is in progress. It is 0 from the cycle after acceptance until the cycle after `doneValid`.
- R7: While `txnValid` is 1 and `txnReady` is 0, the next cycle still has `txnValid` at 1, with `txnAddr` and `txnMask` unchanged.
- R8: `doneValid` pulses for one cycle together with the final accepted transaction of a request. At that time `doneCount` (6 bits) equals the number of transactions issued.
- R9: After reset, `reqReady` is 1, and `txnValid` and `doneValid` are 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rstN | input | 1 | Active-low synchronous reset |
| reqValid | input | 1 | Request present |
| reqReady | output | 1 | Block idle, request is taken |
| reqAddr | input | NUM_LANES*ADDR_W | Lane byte addresses, lane i at bits [i*ADDR_W +: ADDR_W] |
| reqMask | input | NUM_LANES | Lane enables, bit i for lane i |
| txnValid | output | 1 | Transaction present |
| txnReady | input | 1 | Memory side takes the transaction |
| txnAddr | output | ADDR_W | Line-aligned transaction address |
| txnMask | output | NUM_LANES | Lanes served by this transaction |
| doneValid | output | 1 | Request complete pulse |
| doneCount | output | $clog2(NUM_LANES+1) | Transactions issued for the request |

## Verification
The bench builds the block with 32 lanes, 128-byte lines and 16-bit addresses. The narrow address space lets random lane addresses collide on the same few lines often, which exercises partial merges and order by lowest lane. Strides of 1 to 40 elements at each of the three element sizes are swept, and the bench checks the transaction count against a closed-form line-span count. A pseudo-random ready pattern forces back-pressure on many transactions, so the hold rule and the count at the final transaction are checked under stalls.

// File: rtl/coal_pkg.sv
package coal_pkg;

  typedef enum logic {
    ST_IDLE,
    ST_BUSY
  } coalState_t;

  // strobes from control to datapath
  typedef struct packed {
    logic load;    // capture a new request
    logic issue;   // current transaction accepted
    logic finish;  // request completes this cycle
  } coalStrobe_t;

endpackage

// File: rtl/coal_ctrl.sv
module coal_ctrl
  import coal_pkg::*;
(
  input  logic        clk,
  input  logic        rstN,
  input  logic        reqValid,
  input  logic        txnReady,
  input  logic        pendEmpty,
  input  logic        lastTxn,
  output coalStrobe_t strobe,
  output logic        reqReady,
  output logic        txnValid,
  output logic        doneValid
);

  coalState_t stateQ, stateD;

  always_comb begin
    reqReady      = (stateQ == ST_IDLE);
    txnValid      = (stateQ == ST_BUSY) && !pendEmpty;
    strobe.load   = reqReady && reqValid;
    strobe.issue  = txnValid && txnReady;
    strobe.finish = (stateQ == ST_BUSY) && (pendEmpty || (strobe.issue && lastTxn));
    doneValid     = strobe.finish;
  end

  always_comb begin
    stateD = stateQ;
    if (strobe.load)        stateD = ST_BUSY;
    else if (strobe.finish) stateD = ST_IDLE;
  end

  always_ff @(posedge clk) begin
    if (!rstN) stateQ <= ST_IDLE;
    else       stateQ <= stateD;
  end

endmodule

// File: rtl/coal_datapath.sv
module coal_datapath
  import coal_pkg::*;
#(
  parameter int NUM_LANES  = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  localparam int OFF_W     = $clog2(LINE_BYTES),
  localparam int TAG_W     = ADDR_W - OFF_W,
  localparam int LANE_W    = $clog2(NUM_LANES),
  localparam int CNT_W     = $clog2(NUM_LANES + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  coalStrobe_t                 strobe,
  input  logic [NUM_LANES*ADDR_W-1:0] reqAddr,
  input  logic [NUM_LANES-1:0]        reqMask,
  output logic [ADDR_W-1:0]           txnAddr,
  output logic [NUM_LANES-1:0]        txnMask,
  output logic                        pendEmpty,
  output logic                        lastTxn,
  output logic [CNT_W-1:0]            doneCount
);

  logic [TAG_W-1:0]     tagQ [NUM_LANES];
  logic [NUM_LANES-1:0] pendQ;
  logic [CNT_W-1:0]     cntQ;
  logic [LANE_W-1:0]    leader;
  logic [TAG_W-1:0]     leadTag;
  logic [NUM_LANES-1:0] matchMask;

  // line tags per lane, captured on acceptance
  for (genvar g = 0; g < NUM_LANES; g++) begin : g_tag
    logic [ADDR_W-1:0] laneAddr;
    assign laneAddr = reqAddr[g*ADDR_W +: ADDR_W];
    always_ff @(posedge clk) begin
      if (strobe.load) tagQ[g] <= TAG_W'(laneAddr >> OFF_W);
    end
    assign matchMask[g] = pendQ[g] && (tagQ[g] == leadTag);
  end

  // lowest pending lane leads the next transaction
  always_comb begin
    leader = '0;
    for (int i = NUM_LANES - 1; i >= 0; i--) begin
      if (pendQ[i]) leader = LANE_W'(i);
    end
  end

  assign leadTag = tagQ[leader];

  always_ff @(posedge clk) begin
    if (!rstN) begin
      pendQ <= '0;
      cntQ  <= '0;
    end else if (strobe.load) begin
      pendQ <= reqMask;
      cntQ  <= '0;
    end else if (strobe.issue) begin
      pendQ <= pendQ & ~matchMask;
      cntQ  <= cntQ + CNT_W'(1);
    end
  end

  assign txnAddr   = {leadTag, {OFF_W{1'b0}}};
  assign txnMask   = matchMask;
  assign pendEmpty = ~|pendQ;
  assign lastTxn   = ~|(pendQ & ~matchMask);
  assign doneCount = strobe.issue ? cntQ + CNT_W'(1) : cntQ;

endmodule

// File: rtl/warp_coalescer.sv
module warp_coalescer
  import coal_pkg::*;
#(
  parameter int NUM_LANES  = 32,
  parameter int ADDR_W     = 32,
  parameter int LINE_BYTES = 128,
  localparam int CNT_W     = $clog2(NUM_LANES + 1)
) (
  input  logic                        clk,
  input  logic                        rstN,
  input  logic                        reqValid,
  output logic                        reqReady,
  input  logic [NUM_LANES*ADDR_W-1:0] reqAddr,
  input  logic [NUM_LANES-1:0]        reqMask,
  output logic                        txnValid,
  input  logic                        txnReady,
  output logic [ADDR_W-1:0]           txnAddr,
  output logic [NUM_LANES-1:0]        txnMask,
  output logic                        doneValid,
  output logic [CNT_W-1:0]            doneCount
);

  coalStrobe_t strobe;
  logic        pendEmpty;
  logic        lastTxn;

  coal_ctrl ctrl_i (
    .clk       (clk),
    .rstN      (rstN),
    .reqValid  (reqValid),
    .txnReady  (txnReady),
    .pendEmpty (pendEmpty),
    .lastTxn   (lastTxn),
    .strobe    (strobe),
    .reqReady  (reqReady),
    .txnValid  (txnValid),
    .doneValid (doneValid)
  );

  coal_datapath #(
    .NUM_LANES  (NUM_LANES),
    .ADDR_W     (ADDR_W),
    .LINE_BYTES (LINE_BYTES)
  ) dp_i (
    .clk       (clk),
    .rstN      (rstN),
    .strobe    (strobe),
    .reqAddr   (reqAddr),
    .reqMask   (reqMask),
    .txnAddr   (txnAddr),
    .txnMask   (txnMask),
    .pendEmpty (pendEmpty),
    .lastTxn   (lastTxn),
    .doneCount (doneCount)
  );

endmodule

// File: rtl/coal_checker.sv
module coal_checker #(
  parameter int NUM_LANES = 32,
  parameter int ADDR_W    = 32,
  localparam int CNT_W    = $clog2(NUM_LANES + 1)
) (
  input logic                 clk,
  input logic                 rstN,
  input logic                 reqValid,
  input logic                 reqReady,
  input logic [NUM_LANES-1:0] reqMask,
  input logic                 txnValid,
  input logic                 txnReady,
  input logic [ADDR_W-1:0]    txnAddr,
  input logic [NUM_LANES-1:0] txnMask,
  input logic                 doneValid,
  input logic [CNT_W-1:0]     doneCount
);

  logic [NUM_LANES-1:0] activeQ;

  always_ff @(posedge clk) begin
    if (!rstN)                    activeQ <= '0;
    else if (reqValid && reqReady) activeQ <= reqMask;
  end

  // R3: a transaction never has an empty mask; successive masks are disjoint
  p_mask_nonempty_r3: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> (txnMask != '0));
  p_mask_disjoint_r3: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && txnReady) |=> (!txnValid || ((txnMask & $past(txnMask)) == '0)));

  // R4: only lanes enabled at acceptance are served
  p_mask_active_r4: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> ((txnMask & ~activeQ) == '0));

  // R5: empty request completes on the next cycle with count zero
  p_empty_done_r5: assert property (@(posedge clk) disable iff (!rstN)
    (reqValid && reqReady && (reqMask == '0)) |=> (doneValid && (doneCount == '0)));

  // R6: no acceptance while a transaction is offered
  p_busy_block_r6: assert property (@(posedge clk) disable iff (!rstN)
    txnValid |-> !reqReady);

  // R7: stalled transaction holds
  p_hold_r7: assert property (@(posedge clk) disable iff (!rstN)
    (txnValid && !txnReady) |=> (txnValid && $stable(txnAddr) && $stable(txnMask)));

  // R8: completion is a single-cycle pulse with a bounded count
  p_done_pulse_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |=> !doneValid);
  p_count_range_r8: assert property (@(posedge clk) disable iff (!rstN)
    doneValid |-> (doneCount <= CNT_W'(NUM_LANES)));

endmodule

bind warp_coalescer coal_checker #(
  .NUM_LANES (NUM_LANES),
  .ADDR_W    (ADDR_W)
) chk_i (
  .clk       (clk),
  .rstN      (rstN),
  .reqValid  (reqValid),
  .reqReady  (reqReady),
  .reqMask   (reqMask),
  .txnValid  (txnValid),
  .txnReady  (txnReady),
  .txnAddr   (txnAddr),
  .txnMask   (txnMask),
  .doneValid (doneValid),
  .doneCount (doneCount)
);

// File: tb/warp_coalescer_tb_top.sv
`timescale 1ns/1ps
module warp_coalescer_tb_top;

  localparam int LANES = 32;
  localparam int AW    = 16;

  logic              clk = 1'b0;
  logic              rstN;
  logic              reqValid;
  logic              reqReady;
  logic [LANES*AW-1:0] reqAddr;
  logic [LANES-1:0]  reqMask;
  logic              txnValid;
  logic              txnReady;
  logic [AW-1:0]     txnAddr;
  logic [LANES-1:0]  txnMask;
  logic              doneValid;
  logic [5:0]        doneCount;

  int checks = 0;
  int errors = 0;

  logic [AW-1:0]    laneAddr [LANES];
  logic [LANES-1:0] laneMask;
  logic [AW-1:0]    expAddr  [LANES];
  logic [LANES-1:0] expMask  [LANES];
  int               expN;
  logic [15:0]      lfsr = 16'hACE1;

  always #2 clk = ~clk;

  warp_coalescer #(.NUM_LANES(LANES), .ADDR_W(AW), .LINE_BYTES(128)) dut_i (
    .clk(clk), .rstN(rstN), .reqValid(reqValid), .reqReady(reqReady),
    .reqAddr(reqAddr), .reqMask(reqMask), .txnValid(txnValid), .txnReady(txnReady),
    .txnAddr(txnAddr), .txnMask(txnMask), .doneValid(doneValid), .doneCount(doneCount)
  );

  task automatic check(input bit ok, input string req, input longint act, input longint exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  function automatic logic [15:0] nextRand(input logic [15:0] v);
    return {v[14:0], v[15] ^ v[13] ^ v[12] ^ v[10]};
  endfunction

  // expected transaction list from the requirements (R1, R3, R4)
  task automatic buildExp();
    logic [LANES-1:0] pend = laneMask;
    expN = 0;
    while (pend != '0) begin
      int lead = 0;
      logic [LANES-1:0] m = '0;
      for (int i = LANES - 1; i >= 0; i--) if (pend[i]) lead = i;
      for (int i = 0; i < LANES; i++)
        if (pend[i] && ((laneAddr[i] >> 7) == (laneAddr[lead] >> 7))) m[i] = 1'b1;
      expAddr[expN] = laneAddr[lead] & ~16'h007F;
      expMask[expN] = m;
      pend = pend & ~m;
      expN++;
    end
  endtask

  // arithN: closed-form count, or -1 when not applicable
  task automatic runReq(input int arithN);
    int k = 0;
    int cyc = 0;
    bit done = 0;
    bit held = 0;
    logic [AW-1:0] hAddr;
    logic [LANES-1:0] hMask;
    buildExp();
    if (arithN >= 0) check(expN == arithN, "R2 line-span count", expN, arithN);
    @(negedge clk);
    for (int i = 0; i < LANES; i++) reqAddr[i*AW +: AW] = laneAddr[i];
    reqMask  = laneMask;
    reqValid = 1'b1;
    @(posedge clk);
    @(negedge clk);
    reqValid = 1'b0;
    reqAddr  = '1;
    reqMask  = '1;
    while (!done && cyc < 200) begin
      lfsr = nextRand(lfsr);
      txnReady = (lfsr[1:0] != 2'b00);
      #1;
      if (held) check(txnValid && txnAddr == hAddr && txnMask == hMask, "R7 hold", txnMask, hMask);
      check(reqReady == 1'b0, "R6 busy", reqReady, 0);
      held = 0;
      if (txnValid) begin
        if (k >= expN) check(0, "R2 extra transaction", k, expN);
        else begin
          check(txnAddr == expAddr[k], "R1 line address", txnAddr, expAddr[k]);
          check(txnMask == expMask[k], "R3 lane mask", txnMask, expMask[k]);
          check((txnMask & ~laneMask) == '0, "R4 inactive lane", txnMask, laneMask);
        end
        if (txnReady) k++;
        else begin held = 1; hAddr = txnAddr; hMask = txnMask; end
      end
      if (doneValid) begin
        done = 1;
        check(doneCount == 6'(expN), "R8 done count", doneCount, expN);
        check(k == expN, "R8 done with final transaction", k, expN);
        if (expN == 0) check(cyc == 0, "R5 empty done timing", cyc, 0);
      end
      @(negedge clk);
      cyc++;
      if (!done && cyc >= 200) check(0, "R8 request never completed", cyc, 200);
    end
    #1;
    check(reqReady == 1'b1, "R6 ready after done", reqReady, 1);
    check(doneValid == 1'b0, "R8 single pulse", doneValid, 0);
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    errors++;
    $display("FAIL watchdog actual=expired expected=finished");
    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    rstN = 1'b0; reqValid = 1'b0; reqAddr = '0; reqMask = '0; txnReady = 1'b0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rstN = 1'b1;
    #1;
    check(reqReady == 1'b1, "R9 reset ready", reqReady, 1);
    check(txnValid == 1'b0, "R9 reset txnValid", txnValid, 0);
    check(doneValid == 1'b0, "R9 reset doneValid", doneValid, 0);

    // R2: contiguous elements of 1, 2, 4 bytes in one aligned line
    for (int es = 1; es <= 4; es = es * 2) begin
      for (int i = 0; i < LANES; i++) laneAddr[i] = 16'(16'h0400 + i * es);
      laneMask = '1;
      runReq(1);
    end

    // R2: stride sweep at each element size, aligned and offset bases
    for (int es = 1; es <= 4; es = es * 2)
      for (int st = 1; st <= 40; st++)
        for (int off = 0; off < 2; off++) begin
          int sb = es * st;
          int base = 16'h1000 + off * es * 3;
          int n = (sb > 128) ? 32 : (((base + 31 * sb) >> 7) - (base >> 7) + 1);
          for (int i = 0; i < LANES; i++) laneAddr[i] = 16'(base + i * sb);
          laneMask = '1;
          runReq(n);
        end

    // R3: lines in reverse lane order, one lane each
    for (int i = 0; i < LANES; i++) laneAddr[i] = 16'(16'h2000 + (31 - i) * 128);
    laneMask = '1;
    runReq(32);

    // R3: two interleaved lines
    for (int i = 0; i < LANES; i++) laneAddr[i] = 16'((i % 2) ? 16'h3080 + i : 16'h3000 + i);
    laneMask = '1;
    runReq(2);

    // R4: inactive lanes point at far lines and must not matter
    for (int i = 0; i < LANES; i++) laneAddr[i] = 16'((i % 2) ? 16'h5000 + i * 256 : 16'h4000 + i * 4);
    laneMask = 32'h5555_5555;
    runReq(1);

    // R5: no active lanes
    laneMask = '0;
    runReq(0);

    // single active lane
    laneMask = 32'h0001_0000;
    runReq(1);

    // random addresses over eight lines with random masks
    for (int t = 0; t < 60; t++) begin
      for (int i = 0; i < LANES; i++) begin
        lfsr = nextRand(lfsr);
        laneAddr[i] = {6'd0, lfsr[9:0]};
      end
      lfsr = nextRand(lfsr); laneMask[15:0]  = lfsr;
      lfsr = nextRand(lfsr); laneMask[31:16] = lfsr;
      runReq(-1);
    end

    $display("  CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

endmodule